// File: doc/BRIEF.md
# Pin-Muxed GPIO Controller

A register-mapped controller for sixteen general-purpose pads behind a 16-bit register bus. For every pad a 2-bit function code chooses what the pad carries. One code gives plain software-driven output. The other three route one of three alternate signal groups to the pad, for example a serial transmit line or activity blink signals. The alternate sources themselves are outside the block and arrive as plain input vectors.

Each pad also has a direction bit, in inverted sense: a set bit makes the pad an input, and a clear bit lets it drive. An output data register supplies the values for pads in plain GPIO mode. An input register returns the pad levels after a two-flop synchroniser. Software reaches all of this with single-cycle register writes and combinational reads. Reset leaves every pad as an input with the alternate code 0 selected and the output data cleared.

Top module: `gpio_pinmux`

## Requirements
- R1: After reset the function-select registers read 0x0000, the direction register reads 0xFFFF, the output data register reads 0x0000 and every pad_oe bit is 0.
- R2: Function codes for pads 0..7 live at byte offset 0x200 and those for pads 8..15 at 0x204; pad n (or n-8 in the upper register) uses bits [2k+1:2k] of its register, with k the pad's index in that register, and both registers read back what was written.
- R3: A pad whose function code is 1 drives the matching bit of the output data register on pad_out.
- R4: A pad whose function code is 0, 2 or 3 drives the matching bit of alt_src0, alt_src2 or alt_src3 respectively on pad_out.
- R5: The direction register at 0x208 reads back as written, and pad_oe[n] is the inverse of its bit n from the cycle after the write; no other register write changes pad_oe.
- R6: The output data register at 0x20C reads back as written.
- R7: A read of 0x210 returns pad_in as it was two rising clock edges earlier (two-flop synchroniser).
- R8: Writes to 0x210 and to unmapped offsets change no register and no pad output.
- R9: Reads of unmapped offsets return 0x0000, and rdata is 0 when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, takes effect at the rising edge |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr and current state |
| pad_in | input | 16 | Asynchronous pad input levels |
| alt_src0 | input | 16 | Alternate source selected by function code 0 |
| alt_src2 | input | 16 | Alternate source selected by function code 2 |
| alt_src3 | input | 16 | Alternate source selected by function code 3 |
| pad_out | output | 16 | Value presented to each pad |
| pad_oe | output | 16 | Pad drive enable, high means drive |

## Verification
The bench goes after the split of the function codes across two registers. A design that swaps the halves or mis-packs a field puts the wrong pads into GPIO mode and shows the wrong pad_out bits. It mixes all four codes across the pads so that a swapped alternate source or a wrong GPIO code shows up on specific pads. It checks the inverted direction sense. A block that drives when the bit is set gives a pad_oe that is the complement of the expected value. It times the input path edge by edge, so a missing or extra synchroniser stage returns a value one cycle early or late. Writes to the read-only input offset and to holes are followed by readbacks, because a loose address decode would corrupt a live register. Reads of holes catch a decoder that aliases them.

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pad_in,
  input  logic [DATA_W-1:0] alt_src0,
  input  logic [DATA_W-1:0] alt_src2,
  input  logic [DATA_W-1:0] alt_src3,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe
);
  localparam int NPINS = DATA_W;
  localparam logic [ADDR_W-1:0] OFS_FSEL_LO = ADDR_W'('h200);
  localparam logic [ADDR_W-1:0] OFS_FSEL_HI = ADDR_W'('h204);
  localparam logic [ADDR_W-1:0] OFS_DIR     = ADDR_W'('h208);
  localparam logic [ADDR_W-1:0] OFS_DOUT    = ADDR_W'('h20C);
  localparam logic [ADDR_W-1:0] OFS_DIN     = ADDR_W'('h210);
  localparam logic [1:0] CODE_GPIO = 2'd1;

  logic [DATA_W-1:0]  fsel_lo, fsel_hi, dir_in, dout;
  logic [NPINS-1:0]   sync_a, sync_b;
  logic [2*NPINS-1:0] fsel_all;

  assign fsel_all = {fsel_hi, fsel_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_lo <= '0;
      fsel_hi <= '0;
      dir_in  <= '1;
      dout    <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_FSEL_LO: fsel_lo <= wdata;
        OFS_FSEL_HI: fsel_hi <= wdata;
        OFS_DIR:     dir_in  <= wdata;
        OFS_DOUT:    dout    <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    sync_a <= pad_in;
    sync_b <= sync_a;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_FSEL_LO: rdata = fsel_lo;
        OFS_FSEL_HI: rdata = fsel_hi;
        OFS_DIR:     rdata = dir_in;
        OFS_DOUT:    rdata = dout;
        OFS_DIN:     rdata = sync_b;
        default:     rdata = '0;
      endcase
    end
  end

  assign pad_oe = ~dir_in;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] code;
    assign code = fsel_all[2*p +: 2];
    always_comb begin
      case (code)
        CODE_GPIO: pad_out[p] = dout[p];
        2'd2:      pad_out[p] = alt_src2[p];
        2'd3:      pad_out[p] = alt_src3[p];
        default:   pad_out[p] = alt_src0[p];
      endcase
    end
  end
endmodule

// File: rtl/gpio_pinmux_chk.sv
module gpio_pinmux_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] pad_in,
  input logic [DATA_W-1:0] pad_oe
);
  logic mapped;
  assign mapped = (addr == ADDR_W'('h200)) || (addr == ADDR_W'('h204)) ||
                  (addr == ADDR_W'('h208)) || (addr == ADDR_W'('h20C)) ||
                  (addr == ADDR_W'('h210));

  AST_RESET_OE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> pad_oe == '0); // R1
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == ADDR_W'('h208)) |=> pad_oe == ~$past(wdata)); // R5
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && addr == ADDR_W'('h208)) |=> $stable(pad_oe)); // R5
  AST_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && addr == ADDR_W'('h210)) |-> rdata == $past(pad_in, 2)); // R7
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (!rd_en || !mapped) |-> rdata == '0); // R9
endmodule

bind gpio_pinmux gpio_pinmux_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/gpio_pinmux_tb_top.sv
`timescale 1ns/1ps
module gpio_pinmux_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0, pad_in = '0;
  logic [15:0] alt_src0 = '0, alt_src2 = '0, alt_src3 = '0;
  logic [15:0] rdata, pad_out, pad_oe;
  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] m_lo = 0, m_hi = 0, m_dout = 0;

  always #2 clk = ~clk;

  gpio_pinmux dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
    .alt_src0(alt_src0), .alt_src2(alt_src2), .alt_src3(alt_src3),
    .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    #1 d = rdata;
    rd_en = 0;
  endtask

  function automatic logic [15:0] exp_out();
    logic [31:0] all;
    logic [15:0] r;
    all = {m_hi, m_lo};
    for (int i = 0; i < 16; i++) begin
      case (all[2*i +: 2])
        2'd1: r[i] = m_dout[i];
        2'd2: r[i] = alt_src2[i];
        2'd3: r[i] = alt_src3[i];
        default: r[i] = alt_src0[i];
      endcase
    end
    return r;
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    rd(12'h200, v); check("R1 fsel_lo", v, 16'h0000);
    rd(12'h204, v); check("R1 fsel_hi", v, 16'h0000);
    rd(12'h208, v); check("R1 dir", v, 16'hFFFF);
    rd(12'h20C, v); check("R1 dout", v, 16'h0000);
    check("R1 pad_oe", pad_oe, 16'h0000);
  endtask

  task automatic t_layout();
    logic [15:0] v;
    m_lo = 16'h5555; m_hi = 16'h0004; m_dout = 16'hFFFF;
    alt_src0 = 0; alt_src2 = 0; alt_src3 = 0;
    wr(12'h200, m_lo); wr(12'h204, m_hi); wr(12'h20C, m_dout);
    rd(12'h200, v); check("R2 lo readback", v, m_lo);
    rd(12'h204, v); check("R2 hi readback", v, m_hi);
    check("R2 pad 9 only in upper", pad_out, 16'h02FF);
  endtask

  task automatic t_gpio_out();
    logic [15:0] v;
    m_lo = 16'h5555; m_hi = 16'h5555; m_dout = 16'hA5C3;
    wr(12'h200, m_lo); wr(12'h204, m_hi); wr(12'h20C, m_dout);
    rd(12'h20C, v); check("R6 dout readback", v, 16'hA5C3);
    #1 check("R3 gpio out", pad_out, 16'hA5C3);
    m_dout = 16'h3C5A; wr(12'h20C, m_dout);
    check("R3 gpio out 2", pad_out, 16'h3C5A);
  endtask

  task automatic t_alt();
    m_lo = 16'h1B1B; m_hi = 16'hFFAA; m_dout = 16'hFFFF;
    alt_src0 = 16'hF0F0; alt_src2 = 16'h0F0F; alt_src3 = 16'hCCCC;
    wr(12'h200, m_lo); wr(12'h204, m_hi); wr(12'h20C, m_dout);
    check("R4 mixed codes", pad_out, exp_out());
    @(negedge clk);
    alt_src0 = ~alt_src0; alt_src2 = ~alt_src2; alt_src3 = ~alt_src3;
    #1 check("R4 alt follow", pad_out, exp_out());
  endtask

  task automatic t_dir();
    logic [15:0] v;
    wr(12'h208, 16'h0F0F);
    check("R5 oe inverted", pad_oe, 16'hF0F0);
    rd(12'h208, v); check("R5 dir readback", v, 16'h0F0F);
    wr(12'h20C, 16'h1234);
    check("R5 oe unaffected", pad_oe, 16'hF0F0);
  endtask

  task automatic t_sync();
    logic [15:0] v;
    pad_in = 16'h0000;
    repeat (3) @(negedge clk);
    pad_in = 16'h1234;
    rd(12'h210, v); check("R7 after one edge", v, 16'h0000);
    rd(12'h210, v); check("R7 after two edges", v, 16'h1234);
  endtask

  task automatic t_ignored();
    logic [15:0] v, oe0, out0;
    oe0 = pad_oe; out0 = pad_out;
    wr(12'h210, 16'hFFFF);
    rd(12'h210, v); check("R8 din write ignored", v, 16'h1234);
    wr(12'h214, 16'hFFFF); wr(12'h000, 16'hFFFF); wr(12'h202, 16'hFFFF);
    rd(12'h200, v); check("R8 lo kept", v, m_lo);
    rd(12'h204, v); check("R8 hi kept", v, m_hi);
    rd(12'h208, v); check("R8 dir kept", v, 16'h0F0F);
    rd(12'h20C, v); check("R8 dout kept", v, 16'h1234);
    check("R8 oe kept", pad_oe, oe0);
    check("R8 out kept", pad_out, out0);
  endtask

  task automatic t_holes();
    logic [15:0] v;
    rd(12'h214, v); check("R9 hole 214", v, 16'h0000);
    rd(12'h202, v); check("R9 hole 202", v, 16'h0000);
    rd(12'h000, v); check("R9 hole 000", v, 16'h0000);
    @(negedge clk); addr = 12'h208; #1 check("R9 no rd_en", rdata, 16'h0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_layout();
    t_gpio_out();
    t_alt();
    t_dir();
    t_sync();
    t_ignored();
    t_holes();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule